// File: doc/BRIEF.md
# DMA Channel Pointer and Configuration Checker

This block keeps the three working registers of a single DMA channel: the source pointer, the destination pointer and the remaining byte count. When the channel is told to start, it checks that the programmed values agree with the configured source and destination port widths. It refuses to run a bad setup and flags the fault instead. While the channel runs, it moves each pointer by its own port width whenever an operand on that side completes. It also takes the wider of the two widths off the byte count for every finished operand, and it reports completion when the count reaches zero.

The surrounding bus engine loads the registers, presents the port widths and increment enables, pulses the start strobe, and then reports operand completions through three strobes. Port widths use a two-bit code: 00 is a four-byte long, 01 is a single byte, 10 is a two-byte word, and 11 is reserved.

The controller has four states. IDLE holds loaded values. RUN advances pointers and count. DONE is reached when the count is exhausted. FAULT holds a rejected setup. The transitions are:
- IDLE to RUN on start with a valid setup.
- IDLE to FAULT on start with an invalid setup.
- RUN to DONE when an operand completion brings the count to zero.
- DONE to IDLE and FAULT to IDLE on a register load.

Top module: `dma_ptr_checker`

## Requirements
- R1: A load (`load_i`) in IDLE, DONE or FAULT writes the source pointer, destination pointer and count from their inputs and enters IDLE. After the next clock edge `busy_o`, `done_o` and `cfg_err_o` are all 0.
- R2: Width code 00 means 4 bytes, 01 means 1 byte and 10 means 2 bytes. Code 11 on either side makes a start fail with a configuration error.
- R3: A start fails when the source pointer is not a multiple of the source width.
- R4: A start fails when the destination pointer is not a multiple of the destination width.
- R5: A start fails when the byte count is not a multiple of the larger of the two widths.
- R6: A start fails when the byte count is zero.
- R7: A start in IDLE enters RUN (`busy_o`=1) one cycle later if the setup is valid. If the setup is invalid, it enters FAULT (`cfg_err_o`=1, `busy_o`=0) one cycle later, and the pointers and count keep their values.
- R8: In RUN, `src_step_i` adds the source width to the source pointer when source increment was enabled at start; otherwise the pointer holds.
- R9: In RUN, `dst_step_i` adds the destination width, not the source width, to the destination pointer when destination increment was enabled at start; otherwise the pointer holds.
- R10: In RUN, `opnd_done_i` subtracts the larger width from the count. When the count becomes zero, the block enters DONE, with `done_o`=1 and `busy_o`=0.
- R11: Widths and increment enables are captured at start, so changes to them during RUN have no effect. Step strobes outside RUN, a load during RUN, and a start outside IDLE are all ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Load the three registers from the inputs |
| src_addr_i | input | AW | Source pointer load value |
| dst_addr_i | input | AW | Destination pointer load value |
| byte_cnt_i | input | CW | Byte count load value |
| src_size_i | input | 2 | Source port width code |
| dst_size_i | input | 2 | Destination port width code |
| src_inc_i | input | 1 | Source pointer increment enable |
| dst_inc_i | input | 1 | Destination pointer increment enable |
| start_i | input | 1 | Start strobe |
| src_step_i | input | 1 | Source operand completed |
| dst_step_i | input | 1 | Destination operand completed |
| opnd_done_i | input | 1 | Full operand transfer completed |
| src_addr_o | output | AW | Current source pointer |
| dst_addr_o | output | AW | Current destination pointer |
| byte_cnt_o | output | CW | Remaining byte count |
| busy_o | output | 1 | Channel in RUN |
| done_o | output | 1 | Channel in DONE |
| cfg_err_o | output | 1 | Channel in FAULT |

## Verification
Every result appears exactly one clock after the strobe that causes it. The pointers and count are registered on the edge that samples a load or step. The status flags are decoded from the state register, which changes on the edge that samples start or the final operand completion. The bench therefore drives each strobe just after a falling edge, lets one rising edge pass, and reads the outputs at the following falling edge. The validity table is run from reset for each row, so that every rejection reason is seen on its own.

// File: rtl/dma_chk_pkg.sv
package dma_chk_pkg;

    typedef enum logic [1:0] {
        SZ_LONG = 2'b00,
        SZ_BYTE = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } port_sz_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_DONE,
        ST_FAULT
    } chan_st_e;

    function automatic logic [2:0] sz_bytes(input port_sz_e s);
        case (s)
            SZ_LONG: sz_bytes = 3'd4;
            SZ_BYTE: sz_bytes = 3'd1;
            SZ_WORD: sz_bytes = 3'd2;
            default: sz_bytes = 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/dma_cfg_check.sv
module dma_cfg_check
    import dma_chk_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 24
) (
    input  logic [AW-1:0] src_addr,
    input  logic [AW-1:0] dst_addr,
    input  logic [CW-1:0] cnt,
    input  port_sz_e      src_sz,
    input  port_sz_e      dst_sz,
    output logic          cfg_bad,
    output logic [2:0]    big_bytes
);
    logic [2:0] s_b, d_b;
    logic [1:0] s_mask, d_mask, big_mask;
    logic       rsvd, s_mis, d_mis, c_mis, c_zero;

    always_comb begin
        s_b       = sz_bytes(src_sz);
        d_b       = sz_bytes(dst_sz);
        big_bytes = (s_b > d_b) ? s_b : d_b;
        s_mask    = 2'(s_b - 3'd1);
        d_mask    = 2'(d_b - 3'd1);
        big_mask  = 2'(big_bytes - 3'd1);
        rsvd      = (src_sz == SZ_RSVD) || (dst_sz == SZ_RSVD);
        s_mis     = |(src_addr[1:0] & s_mask);
        d_mis     = |(dst_addr[1:0] & d_mask);
        c_mis     = |(cnt[1:0] & big_mask);
        c_zero    = (cnt == '0);
        cfg_bad   = rsvd || s_mis || d_mis || c_mis || c_zero;
    end
endmodule

// File: rtl/dma_ptr_step.sv
module dma_ptr_step #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [AW-1:0] ld_val,
    input  logic          step,
    input  logic          inc_en,
    input  logic [2:0]    stride,
    output logic [AW-1:0] addr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            addr <= '0;
        else if (ld)
            addr <= ld_val;
        else if (step && inc_en)
            addr <= addr + AW'(stride);
    end

    // R8 / R9: pointer moves by its own stride
    a_r8_ptr_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (step && inc_en && !ld) |=> addr == $past(addr) + AW'($past(stride)));

    // R11: no load and no enabled step leaves the pointer untouched
    a_r11_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !(step && inc_en)) |=> $stable(addr));
endmodule

// File: rtl/dma_ptr_checker.sv
module dma_ptr_checker
    import dma_chk_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] src_addr_i,
    input  logic [AW-1:0] dst_addr_i,
    input  logic [CW-1:0] byte_cnt_i,
    input  logic [1:0]    src_size_i,
    input  logic [1:0]    dst_size_i,
    input  logic          src_inc_i,
    input  logic          dst_inc_i,
    input  logic          start_i,
    input  logic          src_step_i,
    input  logic          dst_step_i,
    input  logic          opnd_done_i,
    output logic [AW-1:0] src_addr_o,
    output logic [AW-1:0] dst_addr_o,
    output logic [CW-1:0] byte_cnt_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          cfg_err_o
);
    localparam int NPTR = 2;

    chan_st_e   state, state_nx;
    logic       cfg_bad;
    logic [2:0] big_now;
    logic [2:0] big_q, s_stride_q, d_stride_q;
    logic       s_inc_q, d_inc_q;
    logic       ld_ok, go, run;
    logic [CW-1:0] cnt_q;

    dma_cfg_check #(.AW(AW), .CW(CW)) u_chk (
        .src_addr (src_addr_o),
        .dst_addr (dst_addr_o),
        .cnt      (cnt_q),
        .src_sz   (port_sz_e'(src_size_i)),
        .dst_sz   (port_sz_e'(dst_size_i)),
        .cfg_bad  (cfg_bad),
        .big_bytes(big_now)
    );

    assign run   = (state == ST_RUN);
    assign ld_ok = load_i && !run;
    assign go    = (state == ST_IDLE) && start_i && !load_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (go) state_nx = cfg_bad ? ST_FAULT : ST_RUN;
            ST_RUN:   if (opnd_done_i && cnt_q == CW'(big_q)) state_nx = ST_DONE;
            ST_DONE:  if (load_i) state_nx = ST_IDLE;
            ST_FAULT: if (load_i) state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy_o    = (state == ST_RUN);
        done_o    = (state == ST_DONE);
        cfg_err_o = (state == ST_FAULT);
    end

    // configuration captured at start, count register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            big_q      <= 3'd0;
            s_stride_q <= 3'd0;
            d_stride_q <= 3'd0;
            s_inc_q    <= 1'b0;
            d_inc_q    <= 1'b0;
            cnt_q      <= '0;
        end else begin
            if (go) begin
                big_q      <= big_now;
                s_stride_q <= sz_bytes(port_sz_e'(src_size_i));
                d_stride_q <= sz_bytes(port_sz_e'(dst_size_i));
                s_inc_q    <= src_inc_i;
                d_inc_q    <= dst_inc_i;
            end
            if (ld_ok)
                cnt_q <= byte_cnt_i;
            else if (run && opnd_done_i)
                cnt_q <= cnt_q - CW'(big_q);
        end
    end

    assign byte_cnt_o = cnt_q;

    // pointer pair
    logic [AW-1:0] p_ld [NPTR];
    logic [AW-1:0] p_q  [NPTR];
    logic          p_step [NPTR];
    logic          p_inc  [NPTR];
    logic [2:0]    p_str  [NPTR];

    always_comb begin
        p_ld[0]   = src_addr_i;  p_ld[1]   = dst_addr_i;
        p_step[0] = run && src_step_i;
        p_step[1] = run && dst_step_i;
        p_inc[0]  = s_inc_q;     p_inc[1]  = d_inc_q;
        p_str[0]  = s_stride_q;  p_str[1]  = d_stride_q;
    end

    for (genvar i = 0; i < NPTR; i++) begin : g_ptr
        dma_ptr_step #(.AW(AW)) u_ptr (
            .clk   (clk),
            .rst_n (rst_n),
            .ld    (ld_ok),
            .ld_val(p_ld[i]),
            .step  (p_step[i]),
            .inc_en(p_inc[i]),
            .stride(p_str[i]),
            .addr  (p_q[i])
        );
    end

    assign src_addr_o = p_q[0];
    assign dst_addr_o = p_q[1];

    // R10: each completion removes the larger width
    a_r10_cnt_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (run && opnd_done_i && !load_i) |=> byte_cnt_o == $past(byte_cnt_o) - CW'($past(big_q)));

    // R10: completion reported only with an empty count
    a_r10_done_zero: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> byte_cnt_o == '0);

    // R7: a rejected setup never reaches RUN
    a_r7_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (go && cfg_bad) |=> (cfg_err_o && !busy_o));

    // R6: RUN never holds an empty count
    a_r6_run_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> byte_cnt_o != '0);

    // R11: outside RUN the count moves only on a load
    a_r11_cnt_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !run) |=> $stable(byte_cnt_o));
endmodule

// File: tb/tb_dma_ptr_checker.sv
module tb_dma_ptr_checker;
    localparam int AW = 32;
    localparam int CW = 24;
    localparam time PERIOD = 10;
    localparam int NV = 10;

    // {src, dst, cnt, src_size, dst_size, expect_err}
    localparam logic [92:0] VEC [NV] = '{
        {32'h1000, 32'h2000, 24'd16, 2'b00, 2'b00, 1'b0},
        {32'h1001, 32'h2000, 24'd4,  2'b01, 2'b00, 1'b0},
        {32'h1002, 32'h2000, 24'd8,  2'b00, 2'b10, 1'b1},
        {32'h1000, 32'h2001, 24'd8,  2'b10, 2'b10, 1'b1},
        {32'h1000, 32'h2000, 24'd6,  2'b10, 2'b00, 1'b1},
        {32'h1000, 32'h2000, 24'd6,  2'b10, 2'b01, 1'b0},
        {32'h1000, 32'h2000, 24'd0,  2'b01, 2'b01, 1'b1},
        {32'h1000, 32'h2000, 24'd3,  2'b01, 2'b01, 1'b0},
        {32'h1000, 32'h2000, 24'd4,  2'b11, 2'b00, 1'b1},
        {32'h1003, 32'h2002, 24'd2,  2'b01, 2'b10, 1'b0}
    };

    logic clk = 0, rst_n = 0;
    logic load_i = 0, start_i = 0, src_step_i = 0, dst_step_i = 0, opnd_done_i = 0;
    logic [AW-1:0] src_addr_i = '0, dst_addr_i = '0;
    logic [CW-1:0] byte_cnt_i = '0;
    logic [1:0] src_size_i = 2'b00, dst_size_i = 2'b00;
    logic src_inc_i = 1, dst_inc_i = 1;
    logic [AW-1:0] src_addr_o, dst_addr_o;
    logic [CW-1:0] byte_cnt_o;
    logic busy_o, done_o, cfg_err_o;
    int n_chk = 0, n_fail = 0;

    always #(PERIOD/2) clk = ~clk;

    dma_ptr_checker #(.AW(AW), .CW(CW)) dut (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 0; cyc(); cyc(); rst_n = 1;
    endtask

    task automatic load(input logic [31:0] s, input logic [31:0] d, input logic [23:0] c);
        src_addr_i = s; dst_addr_i = d; byte_cnt_i = c;
        load_i = 1; cyc(); load_i = 0;
    endtask

    task automatic pulse_start();  start_i = 1;     cyc(); start_i = 0;     endtask
    task automatic pulse_src();    src_step_i = 1;  cyc(); src_step_i = 0;  endtask
    task automatic pulse_dst();    dst_step_i = 1;  cyc(); dst_step_i = 0;  endtask
    task automatic pulse_opnd();   opnd_done_i = 1; cyc(); opnd_done_i = 0; endtask

    initial begin
        #(PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        cyc(); cyc();
        // reset state
        check("R1 reset busy", 32'(busy_o), 0);
        check("R1 reset done", 32'(done_o), 0);
        check("R1 reset err",  32'(cfg_err_o), 0);
        check("R1 reset cnt",  32'(byte_cnt_o), 0);
        rst_n = 1; cyc();

        // validity table: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            logic [92:0] v;
            v = VEC[i];
            do_reset();
            src_size_i = v[4:3]; dst_size_i = v[2:1];
            load(v[92:61], v[60:29], v[28:5]);
            pulse_start();
            check($sformatf("R2-R7 vec%0d cfg_err", i), 32'(cfg_err_o), 32'(v[0]));
            check($sformatf("R7 vec%0d busy", i), 32'(busy_o), 32'(!v[0]));
        end

        // run 1: byte source, long destination
        do_reset();
        src_size_i = 2'b01; dst_size_i = 2'b00; src_inc_i = 1; dst_inc_i = 1;
        load(32'h101, 32'h200, 24'd8);
        check("R1 load src", src_addr_o, 32'h101);
        pulse_start();
        check("R7 busy", 32'(busy_o), 1);
        src_size_i = 2'b00;  // changed during RUN
        pulse_src();
        check("R8 R11 src by latched byte width", src_addr_o, 32'h102);
        pulse_dst();
        check("R9 dst by dst width", dst_addr_o, 32'h204);
        pulse_opnd();
        check("R10 cnt minus larger", 32'(byte_cnt_o), 4);
        check("R10 still busy", 32'(busy_o), 1);
        pulse_opnd();
        check("R10 cnt zero", 32'(byte_cnt_o), 0);
        check("R10 done", 32'(done_o), 1);
        check("R10 not busy", 32'(busy_o), 0);
        pulse_src();
        check("R11 step outside RUN", src_addr_o, 32'h102);
        pulse_start();
        check("R11 start in DONE", 32'(done_o), 1);
        load(32'h400, 32'h500, 24'd2);
        check("R1 load from DONE done", 32'(done_o), 0);
        check("R1 load from DONE src", src_addr_o, 32'h400);

        // run 2: word/word, source increment off
        src_size_i = 2'b10; dst_size_i = 2'b10; src_inc_i = 0; dst_inc_i = 1;
        pulse_start();
        check("R7 run2 busy", 32'(busy_o), 1);
        pulse_src();
        check("R8 inc off holds", src_addr_o, 32'h400);
        pulse_dst();
        check("R9 dst word step", dst_addr_o, 32'h502);
        load(32'h999, 32'h999, 24'd9);
        check("R11 load in RUN src", src_addr_o, 32'h400);
        check("R11 load in RUN cnt", 32'(byte_cnt_o), 2);

        // rejected start keeps registers
        do_reset();
        src_size_i = 2'b00; dst_size_i = 2'b00;
        load(32'h402, 32'h500, 24'd4);
        pulse_start();
        check("R3 R7 fault", 32'(cfg_err_o), 1);
        check("R7 fault not busy", 32'(busy_o), 0);
        check("R7 fault src kept", src_addr_o, 32'h402);
        check("R7 fault cnt kept", 32'(byte_cnt_o), 4);
        load(32'h400, 32'h500, 24'd4);
        check("R1 load clears fault", 32'(cfg_err_o), 0);
        pulse_start();
        check("R7 valid after fault", 32'(busy_o), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule